// File: doc/BRIEF.md
# Serial Register Access Port

This block is a serial-peripheral slave that lets an external host read and write a bank of internal registers. The host lowers the active-low chip select, then clocks in a command byte. The command byte gives the direction and a 5-bit register address. Data bytes follow, most significant byte first and most significant bit first. The serial clock idles high. The block samples the host's data on each falling clock edge and changes its own output after each rising edge. Because of this, the host can sample the output on the following falling edge.

All serial pins are oversampled by the block's own system clock through synchronizers. The serial clock must therefore run well below the system clock: each serial-clock phase must last at least six system clock cycles. On the register side, the block presents an address with a one-cycle write strobe and right-justified write data. A write is committed only after its last byte has arrived. Reads use a one-cycle read strobe; the whole read value is captured in that cycle and then shifted out byte by byte. The output data line has a separate enable, which is low (line released) except while read data is being returned.

Top module: `spi_reg_slave`

## Requirements
- R1: The command byte is the first byte of every frame, sent MSB first. Bit 7 selects the direction (1 = write, 0 = read), bits 6:5 must be 0, and bits 4:0 hold the register address. A command byte whose bits 6:5 are not both 0 makes the rest of the frame ignored: no write strobe, no read strobe, and the output enable stays low.
- R2: Input data is taken on the falling edge of the serial clock, which idles high. Data changed just after a rising edge and held through the next falling edge is received correctly.
- R3: The output data line changes only in reaction to a rising serial-clock edge. The first read bit (bit 7 of the most significant byte) appears after the rising edge that ends the command byte.
- R4: `spi_miso_oe` is 0 outside the read-data phase, including during command bytes, write frames and ignored frames. It returns to 0 no more than four system clocks after chip select goes high.
- R5: The number of data bytes depends on the address: 0x00–0x03 use 5 bytes, 0x04–0x0F use 2 bytes, 0x10–0x17 use 1 byte, and 0x18–0x1F use 3 bytes.
- R6: A write produces exactly one `reg_wr_en` pulse of one cycle, after the final data byte. The pulse carries the address and the received bytes right-justified in `reg_wr_data`, with unused upper bits zero. Bytes sent beyond the register's width are ignored.
- R7: A read produces exactly one `reg_rd_en` pulse of one cycle, at the end of the command byte, with `reg_addr` valid. `reg_rd_data` is captured in that cycle. Later changes to `reg_rd_data` do not alter the bytes returned.
- R8: Raising chip select ends the frame at once. A write that is missing any byte is never committed, and the next frame starts again with a command byte.
- R9: After reset, `reg_wr_en`, `reg_rd_en` and `spi_miso_oe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from the host, idles high |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| spi_miso_oe | output | 1 | Output enable for the pad; 0 means the line is released |
| reg_addr | output | 5 | Register address of the current frame |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_data | output | 40 | Write data, right-justified |
| reg_rd_en | output | 1 | One-cycle read strobe |
| reg_rd_data | input | 40 | Read data for `reg_addr`, right-justified |

## Verification
Writes followed by readback are run on one address from each width class, using distinct byte patterns. These show that the byte count and the MSB-first byte order are right, and they also show that data is taken on the falling edge: the host changes data at the rising edge, so a block sampling there would shift every bit. Frames with surplus bytes, frames cut short by chip select, and a command with non-zero reserved bits are checked against the strobe queues of the reference model. They tell apart a block that commits too early, one that commits twice, and one that ignores the reserved bits. One read changes the register contents right after the command byte, which tells a captured read from a byte-by-byte fetch. A per-clock monitor checks the output enable and the output edge timing throughout all of these frames.

// File: rtl/spi_rs_pkg.sv
package spi_rs_pkg;

    localparam int ADDR_W    = 5;
    localparam int CMD_W     = 8;
    localparam int MAX_BYTES = 5;
    localparam int DATA_W    = 8 * MAX_BYTES;
    localparam int BITCNT_W  = $clog2(DATA_W + 1);
    localparam int NB_W      = $clog2(MAX_BYTES + 1);

    typedef enum logic [1:0] {
        FS_CMD,
        FS_WRITE,
        FS_READ,
        FS_HOLD
    } frame_st_e;

    typedef struct packed {
        logic              wr;
        logic [1:0]        rsvd;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic mosi;
    } pins_t;

    // Byte width of each register, decoded from the top address bits.
    function automatic logic [NB_W-1:0] reg_nbytes(input logic [ADDR_W-1:0] a);
        case (a[ADDR_W-1 -: 2])
            2'b00:   return a[ADDR_W-3] ? NB_W'(2) : NB_W'(5);
            2'b01:   return NB_W'(2);
            2'b10:   return NB_W'(1);
            default: return NB_W'(3);
        endcase
    endfunction

    function automatic logic [BITCNT_W-1:0] bits_of(input logic [NB_W-1:0] nb);
        return BITCNT_W'(8 * int'(nb));
    endfunction

    function automatic logic cmd_ok(input cmd_t c);
        return c.rsvd == 2'b00;
    endfunction

    // Move a right-justified value so that its first byte sits at the top.
    function automatic logic [DATA_W-1:0] tx_align(input logic [DATA_W-1:0] d,
                                                   input logic [NB_W-1:0]   nb);
        return d << (8 * (MAX_BYTES - int'(nb)));
    endfunction

endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
    parameter int           W       = 3,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d_in;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign d_out = stg[STAGES-1];

endmodule

// File: rtl/spi_rs_edge.sv
module spi_rs_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    output logic rise,
    output logic fall
);

    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= sclk_s;
    end

    assign rise = ~prev_q &  sclk_s;
    assign fall =  prev_q & ~sclk_s;

endmodule

// File: rtl/spi_rs_frame.sv
module spi_rs_frame
    import spi_rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              fall,
    input  logic              mosi,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] reg_addr,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    output logic              rd_phase,
    output logic [NB_W-1:0]   nbytes
);

    frame_st_e           st;
    logic [CMD_W-2:0]    cmd_sh;
    logic [DATA_W-1:0]   rx_sh;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [BITCNT_W-1:0] nbits_q;
    logic [ADDR_W-1:0]   addr_q;
    logic                wr_en_q;
    logic                rd_en_q;
    cmd_t                cmd_nx;

    assign cmd_nx = cmd_t'({cmd_sh, mosi});

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= FS_CMD;
            cmd_sh  <= '0;
            rx_sh   <= '0;
            bit_cnt <= '0;
            nbits_q <= '0;
            addr_q  <= '0;
            wr_en_q <= 1'b0;
            rd_en_q <= 1'b0;
        end else begin
            wr_en_q <= 1'b0;
            rd_en_q <= 1'b0;
            if (!active) begin
                st      <= FS_CMD;
                bit_cnt <= '0;
            end else if (fall) begin
                case (st)
                    FS_CMD: begin
                        cmd_sh <= {cmd_sh[CMD_W-3:0], mosi};
                        if (bit_cnt == BITCNT_W'(CMD_W - 1)) begin
                            bit_cnt <= '0;
                            if (!cmd_ok(cmd_nx)) begin
                                st <= FS_HOLD;
                            end else begin
                                addr_q  <= cmd_nx.addr;
                                nbits_q <= bits_of(reg_nbytes(cmd_nx.addr));
                                if (cmd_nx.wr) begin
                                    rx_sh <= '0;
                                    st    <= FS_WRITE;
                                end else begin
                                    rd_en_q <= 1'b1;
                                    st      <= FS_READ;
                                end
                            end
                        end else begin
                            bit_cnt <= bit_cnt + BITCNT_W'(1);
                        end
                    end
                    FS_WRITE: begin
                        rx_sh <= {rx_sh[DATA_W-2:0], mosi};
                        if (bit_cnt == nbits_q - BITCNT_W'(1)) begin
                            wr_en_q <= 1'b1;
                            st      <= FS_HOLD;
                        end else begin
                            bit_cnt <= bit_cnt + BITCNT_W'(1);
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign reg_wr_en   = wr_en_q;
    assign reg_rd_en   = rd_en_q;
    assign reg_addr    = addr_q;
    assign reg_wr_data = rx_sh;
    assign rd_phase    = (st == FS_READ);
    assign nbytes      = reg_nbytes(addr_q);

    // R1: a command with reserved bits set is dropped without a read strobe
    a_r1_bad_cmd_dropped: assert property (@(posedge clk) disable iff (rst)
        (active && fall && st == FS_CMD && bit_cnt == BITCNT_W'(CMD_W - 1) && !cmd_ok(cmd_nx))
        |=> (st == FS_HOLD && !rd_en_q));

    // R2: the receive shifter moves only on a falling serial-clock edge
    a_r2_shift_on_fall: assert property (@(posedge clk) disable iff (rst)
        (st == FS_WRITE && !fall) |=> $stable(rx_sh));

    // R6: the write strobe is a single-cycle pulse
    a_r6_single_commit: assert property (@(posedge clk) disable iff (rst)
        wr_en_q |=> !wr_en_q);

    // R7: the read strobe is a single-cycle pulse
    a_r7_single_fetch: assert property (@(posedge clk) disable iff (rst)
        rd_en_q |=> !rd_en_q);

    // R8: no commit in the cycle after chip select is seen released
    a_r8_abort_no_commit: assert property (@(posedge clk) disable iff (rst)
        !active |=> !wr_en_q);

endmodule

// File: rtl/spi_rs_tx.sv
module spi_rs_tx
    import spi_rs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              rise,
    input  logic              rd_phase,
    input  logic              load,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [NB_W-1:0]   nbytes,
    output logic              miso,
    output logic              miso_oe
);

    logic [DATA_W-1:0] tx_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= '0;
            miso    <= 1'b0;
            miso_oe <= 1'b0;
        end else if (!active) begin
            miso_oe <= 1'b0;
        end else if (load) begin
            tx_sh <= tx_align(rd_data, nbytes);
        end else if (rd_phase && rise) begin
            miso    <= tx_sh[DATA_W-1];
            tx_sh   <= {tx_sh[DATA_W-2:0], 1'b0};
            miso_oe <= 1'b1;
        end
    end

    // R3: the output bit changes only after a rising serial-clock edge
    a_r3_miso_on_rise: assert property (@(posedge clk) disable iff (rst)
        !rise |=> $stable(miso));

    // R4: the line is released once chip select is seen high
    a_r4_release_on_cs: assert property (@(posedge clk) disable iff (rst)
        !active |=> !miso_oe);

    // R4: the line is driven only during the read-data phase
    a_r4_drive_only_in_read: assert property (@(posedge clk) disable iff (rst)
        miso_oe |-> rd_phase);

endmodule

// File: rtl/spi_reg_slave.sv
module spi_reg_slave
    import spi_rs_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sclk,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] reg_wr_data,
    output logic              reg_rd_en,
    input  logic [DATA_W-1:0] reg_rd_data
);

    localparam int    PIN_W    = $bits(pins_t);
    localparam pins_t PIN_IDLE = '{cs_n: 1'b1, sclk: 1'b1, mosi: 1'b0};

    pins_t            pins_raw;
    pins_t            pins_s;
    logic [PIN_W-1:0] pins_sync;
    logic             active;
    logic             sclk_rise;
    logic             sclk_fall;
    logic             rd_phase;
    logic [NB_W-1:0]  nbytes;

    assign pins_raw = '{cs_n: spi_cs_n, sclk: spi_sclk, mosi: spi_mosi};

    spi_rs_sync #(
        .W       (PIN_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PIN_IDLE)
    ) i_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (pins_raw),
        .d_out (pins_sync)
    );

    assign pins_s = pins_t'(pins_sync);
    assign active = ~pins_s.cs_n;

    spi_rs_edge i_edge (
        .clk    (clk),
        .rst    (rst),
        .sclk_s (pins_s.sclk),
        .rise   (sclk_rise),
        .fall   (sclk_fall)
    );

    spi_rs_frame i_frame (
        .clk         (clk),
        .rst         (rst),
        .active      (active),
        .fall        (sclk_fall),
        .mosi        (pins_s.mosi),
        .reg_wr_en   (reg_wr_en),
        .reg_addr    (reg_addr),
        .reg_wr_data (reg_wr_data),
        .reg_rd_en   (reg_rd_en),
        .rd_phase    (rd_phase),
        .nbytes      (nbytes)
    );

    spi_rs_tx i_tx (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .rise     (sclk_rise),
        .rd_phase (rd_phase),
        .load     (reg_rd_en),
        .rd_data  (reg_rd_data),
        .nbytes   (nbytes),
        .miso     (spi_miso),
        .miso_oe  (spi_miso_oe)
    );

endmodule

// File: tb/test_spi_reg_slave.sv
module test_spi_reg_slave;

    localparam int HP = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        mosi = 1'b0;
    logic        miso;
    logic        miso_oe;
    logic [4:0]  reg_addr;
    logic        reg_wr_en;
    logic        reg_rd_en;
    logic [39:0] reg_wr_data;
    logic [39:0] reg_rd_data;

    always #2 clk = ~clk;

    spi_reg_slave i_spi_reg_slave (
        .clk         (clk),
        .rst         (rst),
        .spi_sclk    (sclk),
        .spi_cs_n    (cs_n),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (miso_oe),
        .reg_addr    (reg_addr),
        .reg_wr_en   (reg_wr_en),
        .reg_wr_data (reg_wr_data),
        .reg_rd_en   (reg_rd_en),
        .reg_rd_data (reg_rd_data)
    );

    // Register bank on the far side of the port, and the bench's own model.
    logic [39:0] rf  [32];
    logic [39:0] mdl [32];
    assign reg_rd_data = rf[reg_addr];
    always @(posedge clk) if (!rst && reg_wr_en) rf[reg_addr] <= reg_wr_data;

    int          compared = 0;
    int          mismatched = 0;
    int          exp_oe = 0;
    int          cs_high_cnt = 0;
    int          since_rise = 100;
    int          cyc = 0;
    logic        prev_sclk = 1'b1;
    logic        prev_miso = 1'b0;
    logic        mon_on = 1'b0;
    logic [44:0] wq[$];
    logic [4:0]  rq[$];

    function automatic int nbytes_of(input int a);
        if (a < 4)  return 5;
        if (a < 16) return 2;
        if (a < 24) return 1;
        return 3;
    endfunction

    function automatic logic [39:0] mask_of(input int n);
        if (n >= 5) return '1;
        return (40'd1 << (8 * n)) - 40'd1;
    endfunction

    task automatic chk(input string req, input logic [63:0] act,
                       input logic [63:0] exp, input string what);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    // Per-clock comparison against the reference expectations.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            summary();
            $finish;
        end
        if (mon_on) begin
            if (cs_n) cs_high_cnt++; else cs_high_cnt = 0;
            if (sclk && !prev_sclk) since_rise = 0;
            else if (since_rise < 1000) since_rise++;
            prev_sclk = sclk;

            if (cs_high_cnt >= 4)  chk("R4", miso_oe, 0, "released while deselected");
            else if (exp_oe >= 0)  chk("R4", miso_oe, 64'(exp_oe), "output enable");

            if (miso_oe && miso !== prev_miso)
                chk("R3", since_rise <= 5, 1, "output changed away from a rising edge");
            prev_miso = miso;

            if (reg_wr_en) begin
                if (wq.size() == 0) chk("R6", 1, 0, "unexpected write strobe");
                else begin
                    logic [44:0] e;
                    e = wq.pop_front();
                    chk("R6", {reg_addr, reg_wr_data}, e, "write address and data");
                end
            end
            if (reg_rd_en) begin
                if (rq.size() == 0) chk("R7", 1, 0, "unexpected read strobe");
                else begin
                    logic [4:0] ea;
                    ea = rq.pop_front();
                    chk("R7", reg_addr, ea, "read strobe address");
                end
            end
        end
    end

    task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HP) @(negedge clk);
            rx[i] = miso;
            sclk = 1'b0;
            repeat (HP) @(negedge clk);
            sclk = 1'b1;
        end
    endtask

    task automatic cs_begin;
        cs_n = 1'b0;
        repeat (HP) @(negedge clk);
    endtask

    task automatic cs_end;
        repeat (HP) @(negedge clk);
        cs_n = 1'b1;
        repeat (4 * HP) @(negedge clk);
    endtask

    task automatic wr_reg(input int a, input logic [39:0] v, input int nsend, input int extra);
        int          n;
        logic [39:0] m;
        logic [7:0]  rx;
        n = nbytes_of(a);
        m = v & mask_of(n);
        if (nsend >= n) begin
            wq.push_back({5'(a), m});
            mdl[a] = m;
        end
        cs_begin();
        xfer({3'b100, 5'(a)}, rx);
        for (int k = 0; k < nsend && k < n; k++) xfer(m[8*(n-1-k) +: 8], rx);
        for (int e = 0; e < extra; e++) xfer(8'h5A, rx);
        cs_end();
    endtask

    task automatic rd_reg(input int a, input int nread, input bit chg, input string tag);
        int          n;
        logic [7:0]  rx;
        logic [39:0] val;
        logic [39:0] expv;
        n = nbytes_of(a);
        rq.push_back(5'(a));
        cs_begin();
        xfer({3'b000, 5'(a)}, rx);
        if (chg) rf[a] = ~rf[a];
        exp_oe = -1;
        repeat (5) @(negedge clk);
        exp_oe = 1;
        val = '0;
        for (int k = 0; k < nread; k++) begin
            xfer(8'h00, rx);
            val = {val[31:0], rx};
        end
        exp_oe = -1;
        cs_end();
        exp_oe = 0;
        expv = mdl[a] >> (8 * (n - nread));
        chk(tag, val, expv, $sformatf("read data of register %0h", a));
        chk("R4", miso_oe, 0, "released after read frame");
    endtask

    initial begin
        logic [7:0] rx;
        for (int i = 0; i < 32; i++) begin
            rf[i]  = '0;
            mdl[i] = '0;
        end
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state
        chk("R9", reg_wr_en, 0, "write strobe after reset");
        chk("R9", reg_rd_en, 0, "read strobe after reset");
        chk("R9", miso_oe, 0, "output enable after reset");
        mon_on = 1'b1;

        // R2 R5 R6: one write per width class, then readback
        wr_reg(8'h02, 40'hA1B2C3D4E5, 5, 0);
        wr_reg(8'h05, 40'h000000BEEF, 2, 0);
        wr_reg(8'h12, 40'h00000000C7, 1, 0);
        wr_reg(8'h1C, 40'h0000F00D42, 3, 0);
        rd_reg(8'h02, 5, 1'b0, "R5");
        rd_reg(8'h05, 2, 1'b0, "R5");
        rd_reg(8'h12, 1, 1'b0, "R5");
        rd_reg(8'h1C, 3, 1'b0, "R2");

        // R6: surplus bytes after a 1-byte register are ignored
        wr_reg(8'h13, 40'h000000003C, 1, 2);
        rd_reg(8'h13, 1, 1'b0, "R6");

        // R8: write cut short after its first byte is never committed
        wr_reg(8'h0A, 40'h000000CAFE, 2, 0);
        wr_reg(8'h0A, 40'h0000001234, 1, 0);
        chk("R8", wq.size(), 0, "pending writes after abort");
        rd_reg(8'h0A, 2, 1'b0, "R8");

        // R1: reserved bits set (command 0xA5 addresses 0x05) drop the frame
        cs_begin();
        xfer(8'hA5, rx);
        xfer(8'hFF, rx);
        xfer(8'hFF, rx);
        cs_end();
        chk("R1", wq.size() + rq.size(), 0, "strobes left after bad command");
        rd_reg(8'h05, 2, 1'b0, "R1");

        // R7: register changes after the command byte do not reach the host
        wr_reg(8'h01, 40'h0123456789, 5, 0);
        rd_reg(8'h01, 5, 1'b1, "R7");

        // R8: read cut short mid-value, then a fresh frame
        wr_reg(8'h1F, 40'h0000ABCDEF, 3, 0);
        rd_reg(8'h1F, 1, 1'b0, "R8");
        rd_reg(8'h1F, 3, 1'b0, "R8");

        repeat (20) @(negedge clk);
        chk("R6", wq.size(), 0, "writes never seen");
        chk("R7", rq.size(), 0, "reads never seen");
        summary();
        $finish;
    end

endmodule